// File: doc/BRIEF.md
# Two-Way Cache Miss Delay Tracker

This block is a timing model of a small data cache. It holds no data. It keeps only the tags, valid bits and replacement state of a two-way set-associative cache whose lines are 16 bytes long. It watches a stream of byte addresses with a read/write flag, one access per accepted cycle. It decides whether each access hits or misses. Three saturating counters record the hits, the misses and the stall cycles that such a cache would cause.

The write policy is write-through and write no-allocate. Every write costs a fixed forwarding penalty, whether it hits or misses, and a write never installs a line. Only a read miss fills a way, and it costs a configurable miss penalty. A performance study drives the access stream from a trace or a live core and reads the counters at the end.

Top module: `cacheDelayTracker`

## Requirements
- R1: After reset, all three counters read zero, every line is invalid so the first read of any block misses, and `accReady` goes high one cycle after reset is released.
- R2: Address bits [3:0] are the byte offset and play no part in the lookup. The set index is the `log2(SET_COUNT)` bits directly above them, and the tag is all bits above the index. Two addresses that differ only in bits [3:0] hit the same line.
- R3: A read that misses increments the miss counter, adds MISS_PENALTY to the delay counter and installs its tag in the set's least-recently-used way.
- R4: A read that hits increments the hit counter and leaves the delay counter unchanged.
- R5: A write that hits increments the hit counter, adds WRITE_PENALTY to the delay counter, keeps the line valid and marks that way as most recently used.
- R6: A write that misses increments the miss counter, adds WRITE_PENALTY to the delay counter and installs nothing, so a later read of the same block still misses.
- R7: Each set has two ways and one replacement bit. Every read fill and every hit, read or write, points the bit at the other way. A third distinct tag in a set evicts the way that was used least recently, and one tag never sits in both ways of a set.
- R8: Each counter stops at its all-ones value instead of wrapping, and it never decreases.
- R9: While `accValid` is low, no counter and no tag or replacement state changes, whatever the address and write inputs carry.
- R10: Sets are independent. A fill or a hit in one set leaves the lines and replacement bits of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accReady | output | 1 | The model accepts accesses; high from the first cycle after reset |
| accAddr | input | ADDR_W | Byte address of the access |
| accWrite | input | 1 | 1 for a write, 0 for a read |
| hitCount | output | CNT_W | Saturating count of hits |
| missCount | output | CNT_W | Saturating count of misses |
| delayCount | output | CNT_W | Saturating count of stall cycles |

## Verification
On every cycle, the assertions check that a tag is never held in both ways of a set. They also check that the counters never move backwards and stay at their ceiling once they reach it, and that each class of access (read hit, read miss, write, idle) changes the delay counter by exactly its penalty. What they cannot see is whether a hit was judged correctly in the first place. Only the bench's sequences can show that: offset aliasing, write no-allocate followed by a read, the choice of victim after a mixed run of read and write hits, and isolation between sets. The bench compares those outcomes, and a long seeded random stream, against its own tag model.

// File: rtl/cdtPkg.sv
package cdtPkg;

  // Strobes from the control to the datapath for one accepted access.
  typedef struct packed {
    logic incHit;      // bump hit counter
    logic incMiss;     // bump miss counter
    logic addMissPen;  // read miss stall
    logic addWritePen; // write-through forwarding stall
    logic fillEn;      // install the tag in useWay
    logic useEn;       // mark useWay as most recently used
    logic useWay;      // way touched by this access
  } ctrlStrobes_t;

endpackage

// File: rtl/cdtSatCounter.sv
module cdtSatCounter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             incEn,
  input  logic [CNT_W-1:0] incAmt,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W:0] sumWide;

  assign sumWide = {1'b0, count} + {1'b0, incAmt};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (incEn) begin
      count <= sumWide[CNT_W] ? MAXV : sumWide[CNT_W-1:0];
    end
  end

  // R8: never moves backwards
  assert_monotonic_R8: assert property (@(posedge clk) disable iff (!rstN)
    count >= $past(count));

  // R8: pinned at the ceiling once reached
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (count == MAXV) |=> (count == MAXV));

endmodule

// File: rtl/cdtTagStore.sv
module cdtTagStore #(
  parameter int SET_COUNT = 4,
  parameter int TAG_W     = 26,
  localparam int SET_BITS = $clog2(SET_COUNT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SET_BITS-1:0] setIdx,
  input  logic [TAG_W-1:0]    tagIn,
  input  logic                fillEn,
  input  logic                useEn,
  input  logic                useWay,
  output logic [1:0]          hitVec,
  output logic                victimWay
);

  localparam int WAYS = 2;

  logic [SET_COUNT-1:0] lruQ;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SET_COUNT-1:0] validQ;
      logic [TAG_W-1:0]     tagQ [SET_COUNT];

      assign hitVec[w] = validQ[setIdx] && (tagQ[setIdx] == tagIn);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          validQ <= '0;
          for (int s = 0; s < SET_COUNT; s++) tagQ[s] <= '0;
        end else if (fillEn && (useWay == 1'(w))) begin
          validQ[setIdx] <= 1'b1;
          tagQ[setIdx]   <= tagIn;
        end
      end
    end
  endgenerate

  assign victimWay = lruQ[setIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lruQ <= '0;
    end else if (useEn) begin
      lruQ[setIdx] <= ~useWay;
    end
  end

  // R7: a tag is never resident in both ways of one set
  assert_single_way_hit_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R7: after a fill the installed tag hits on the following cycle if probed
  assert_fill_lands_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !useWay) |=> g_way[0].validQ[$past(setIdx)]);

  // R9: without a use strobe the replacement bits hold
  assert_lru_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !useEn |=> $stable(lruQ));

endmodule

// File: rtl/cdtDatapath.sv
module cdtDatapath
  import cdtPkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SET_COUNT     = 4,
  parameter int OFF_BITS      = 4,
  parameter int CNT_W         = 32,
  parameter int MISS_PENALTY  = 10,
  parameter int WRITE_PENALTY = 2,
  localparam int SET_BITS     = $clog2(SET_COUNT),
  localparam int TAG_W        = ADDR_W - OFF_BITS - SET_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  ctrlStrobes_t      strb,
  output logic [1:0]        hitVec,
  output logic              victimWay,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount,
  output logic [CNT_W-1:0]  delayCount
);

  localparam int NUM_CNT = 3;
  localparam logic [CNT_W-1:0] MAXV     = '1;
  localparam logic [CNT_W-1:0] MISS_AMT = CNT_W'(MISS_PENALTY);
  localparam logic [CNT_W-1:0] WR_AMT   = CNT_W'(WRITE_PENALTY);

  logic [SET_BITS-1:0] setIdx;
  logic [TAG_W-1:0]    tagIn;
  logic                unusedOffset;

  assign setIdx       = accAddr[OFF_BITS +: SET_BITS];
  assign tagIn        = accAddr[ADDR_W-1 -: TAG_W];
  assign unusedOffset = ^accAddr[OFF_BITS-1:0];

  cdtTagStore #(
    .SET_COUNT(SET_COUNT),
    .TAG_W    (TAG_W)
  ) i_tagStore (
    .clk      (clk),
    .rstN     (rstN),
    .setIdx   (setIdx),
    .tagIn    (tagIn),
    .fillEn   (strb.fillEn),
    .useEn    (strb.useEn),
    .useWay   (strb.useWay),
    .hitVec   (hitVec),
    .victimWay(victimWay)
  );

  logic             cntEn  [NUM_CNT];
  logic [CNT_W-1:0] cntAmt [NUM_CNT];
  logic [CNT_W-1:0] cntVal [NUM_CNT];

  always_comb begin
    cntEn[0]  = strb.incHit;
    cntAmt[0] = CNT_W'(1);
    cntEn[1]  = strb.incMiss;
    cntAmt[1] = CNT_W'(1);
    cntEn[2]  = strb.addMissPen | strb.addWritePen;
    cntAmt[2] = strb.addMissPen ? MISS_AMT : (strb.addWritePen ? WR_AMT : '0);
  end

  generate
    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
      cdtSatCounter #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rstN  (rstN),
        .incEn (cntEn[c]),
        .incAmt(cntAmt[c]),
        .count (cntVal[c])
      );
    end
  endgenerate

  assign hitCount   = cntVal[0];
  assign missCount  = cntVal[1];
  assign delayCount = cntVal[2];

  // R4: a read hit costs no stall cycles
  assert_read_hit_free_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incHit && !strb.addWritePen) |=> $stable(delayCount));

  // R3: a read miss costs exactly the miss penalty (or saturates)
  assert_read_miss_cost_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.addMissPen |=> (delayCount == $past(delayCount) + MISS_AMT) || (delayCount == MAXV));

  // R5 / R6: every write costs exactly the write penalty (or saturates)
  assert_write_cost_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.addWritePen |=> (delayCount == $past(delayCount) + WR_AMT) || (delayCount == MAXV));

  // R9: idle cycles leave every counter alone
  assert_idle_counters_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.incHit && !strb.incMiss) |=>
      ($stable(hitCount) && $stable(missCount) && $stable(delayCount)));

endmodule

// File: rtl/cdtCtrl.sv
module cdtCtrl
  import cdtPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         accValid,
  input  logic         accWrite,
  input  logic [1:0]   hitVec,
  input  logic         victimWay,
  output logic         accReady,
  output ctrlStrobes_t strb
);

  logic readyQ;
  logic accept;
  logic isHit;

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign accReady = readyQ;
  assign accept   = accValid && readyQ;
  assign isHit    = |hitVec;

  always_comb begin
    strb             = '0;
    strb.incHit      = accept && isHit;
    strb.incMiss     = accept && !isHit;
    strb.addMissPen  = accept && !isHit && !accWrite;
    strb.addWritePen = accept && accWrite;
    strb.fillEn      = accept && !isHit && !accWrite;
    strb.useEn       = accept && (isHit || !accWrite);
    strb.useWay      = isHit ? hitVec[1] : victimWay;
  end

  // R6: a write access never installs a line
  assert_write_no_fill_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite) |-> !strb.fillEn);

  // R1: ready stays high once it has risen after reset
  assert_ready_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    accReady |=> accReady);

endmodule

// File: rtl/cacheDelayTracker.sv
module cacheDelayTracker
  import cdtPkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SET_COUNT     = 4,
  parameter int BLOCK_WORDS   = 4,
  parameter int WORD_BYTES    = 4,
  parameter int CNT_W         = 32,
  parameter int MISS_PENALTY  = 10,
  parameter int WRITE_PENALTY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  output logic              accReady,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount,
  output logic [CNT_W-1:0]  delayCount
);

  localparam int OFF_BITS = $clog2(BLOCK_WORDS * WORD_BYTES);

  ctrlStrobes_t strb;
  logic [1:0]   hitVec;
  logic         victimWay;

  cdtCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .accWrite (accWrite),
    .hitVec   (hitVec),
    .victimWay(victimWay),
    .accReady (accReady),
    .strb     (strb)
  );

  cdtDatapath #(
    .ADDR_W       (ADDR_W),
    .SET_COUNT    (SET_COUNT),
    .OFF_BITS     (OFF_BITS),
    .CNT_W        (CNT_W),
    .MISS_PENALTY (MISS_PENALTY),
    .WRITE_PENALTY(WRITE_PENALTY)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .accAddr   (accAddr),
    .strb      (strb),
    .hitVec    (hitVec),
    .victimWay (victimWay),
    .hitCount  (hitCount),
    .missCount (missCount),
    .delayCount(delayCount)
  );

endmodule

// File: tb/test_cacheDelayTracker.sv
module test_cacheDelayTracker;

  localparam int ADDR_W = 32;
  localparam int SETS   = 4;
  localparam int CNT_W  = 10;
  localparam int MISS_P = 10;
  localparam int WR_P   = 2;
  localparam longint MAXV = (64'd1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic accReady;
  logic [ADDR_W-1:0] accAddr = '0;
  logic accWrite = 1'b0;
  logic [CNT_W-1:0] hitCount, missCount, delayCount;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  cacheDelayTracker #(
    .ADDR_W(ADDR_W), .SET_COUNT(SETS), .CNT_W(CNT_W),
    .MISS_PENALTY(MISS_P), .WRITE_PENALTY(WR_P)
  ) i_cacheDelayTracker (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accReady(accReady),
    .accAddr(accAddr), .accWrite(accWrite),
    .hitCount(hitCount), .missCount(missCount), .delayCount(delayCount)
  );

  // Independent tag model: offset [3:0], set [5:4], tag [31:6]
  logic        mValid [SETS][2];
  logic [31:0] mTag   [SETS][2];
  logic        mLru   [SETS];
  longint mHit, mMiss, mDelay;

  function automatic int setOf(input logic [31:0] a);
    return int'(a[5:4]);
  endfunction

  function automatic logic [31:0] tagOf(input logic [31:0] a);
    return a >> 6;
  endfunction

  function automatic logic [31:0] mk(input int t, input int s, input int o);
    return (32'(t) << 6) | (32'(s) << 4) | 32'(o);
  endfunction

  function automatic int modelWay(input logic [31:0] a);
    for (int w = 0; w < 2; w++)
      if (mValid[setOf(a)][w] && mTag[setOf(a)][w] == tagOf(a)) return w;
    return -1;
  endfunction

  function automatic longint satAdd(input longint v, input longint d);
    return (v + d > MAXV) ? MAXV : v + d;
  endfunction

  task automatic modelReset();
    for (int s = 0; s < SETS; s++) begin
      mLru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin mValid[s][w] = 1'b0; mTag[s][w] = '0; end
    end
    mHit = 0; mMiss = 0; mDelay = 0;
  endtask

  task automatic modelAccess(input logic [31:0] a, input logic wr);
    int w = modelWay(a);
    int s = setOf(a);
    if (w >= 0) begin
      mHit = satAdd(mHit, 1);
      mLru[s] = (w == 0);
      if (wr) mDelay = satAdd(mDelay, WR_P);
    end else begin
      mMiss = satAdd(mMiss, 1);
      if (wr) mDelay = satAdd(mDelay, WR_P);
      else begin
        int v = int'(mLru[s]);
        mValid[s][v] = 1'b1;
        mTag[s][v] = tagOf(a);
        mDelay = satAdd(mDelay, MISS_P);
        mLru[s] = (v == 0);
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkCounters(input string req);
    check(longint'(hitCount) == mHit, req, "hitCount", longint'(hitCount), mHit);
    check(longint'(missCount) == mMiss, req, "missCount", longint'(missCount), mMiss);
    check(longint'(delayCount) == mDelay, req, "delayCount", longint'(delayCount), mDelay);
  endtask

  // One access: drive at negedge, registered at posedge, checked at next negedge.
  // expHit: 1 hit, 0 miss, -1 no directed expectation
  task automatic doAcc(input logic [31:0] a, input logic wr, input int expHit, input string req);
    int predicted = (modelWay(a) >= 0) ? 1 : 0;
    if (expHit >= 0) check(predicted == expHit, req, "hit expectation", predicted, expHit);
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accWrite = wr;
    @(negedge clk);
    accValid = 1'b0;
    modelAccess(a, wr);
    checkCounters(req);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; accValid = 1'b0;
    repeat (3) @(negedge clk);
    modelReset();
    check(accReady == 1'b0, "R1", "accReady in reset", accReady, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seedInit = $urandom(32'd2718);
    int lastHit;
    if (seedInit == 0) lastHit = 0;

    doReset();
    check(accReady == 1'b1, "R1", "accReady after reset", accReady, 1);
    checkCounters("R1");

    // Directed sequence in set 0 and set 1
    doAcc(mk(1, 0, 0), 1'b0, 0, "R1");     // first read misses, fills way0
    doAcc(mk(1, 0, 12), 1'b0, 1, "R2");    // same block, other offset: hit, R4 no delay
    doAcc(mk(1, 1, 0), 1'b0, 0, "R10");    // other set misses
    doAcc(mk(2, 0, 0), 1'b1, 0, "R6");     // write miss, no allocate
    doAcc(mk(2, 0, 4), 1'b0, 0, "R6");     // read after write miss still misses, fills way1
    doAcc(mk(2, 0, 8), 1'b0, 1, "R4");     // read hit
    doAcc(mk(1, 0, 4), 1'b1, 1, "R5");     // write hit, way0 becomes MRU
    doAcc(mk(3, 0, 0), 1'b0, 0, "R3");     // read miss evicts way1 (tag 2)
    doAcc(mk(1, 0, 0), 1'b0, 1, "R7");     // tag 1 survived eviction
    doAcc(mk(2, 0, 0), 1'b0, 0, "R7");     // tag 2 was evicted
    doAcc(mk(1, 1, 8), 1'b0, 1, "R10");    // set 1 untouched by set 0 traffic

    // R9: presented but not valid accesses change nothing
    @(negedge clk);
    accValid = 1'b0; accAddr = mk(9, 2, 0); accWrite = 1'b0;
    repeat (4) @(negedge clk);
    accAddr = mk(9, 2, 0); accWrite = 1'b1;
    repeat (2) @(negedge clk);
    checkCounters("R9");
    doAcc(mk(9, 2, 0), 1'b0, 0, "R9");     // block was not installed by idle cycles

    // R8: drive the delay counter into saturation with thrashing read misses
    doReset();
    for (int i = 0; i < 110; i++) begin
      @(negedge clk);
      accValid = 1'b1; accAddr = mk(10 + (i % 3), 3, 0); accWrite = 1'b0;
      @(negedge clk);
      accValid = 1'b0;
      modelAccess(accAddr, 1'b0);
    end
    checkCounters("R8");
    check(longint'(delayCount) == MAXV, "R8", "delay saturated", longint'(delayCount), MAXV);
    doAcc(mk(20, 3, 0), 1'b1, 0, "R8");    // further traffic stays at ceiling
    check(longint'(delayCount) == MAXV, "R8", "delay holds ceiling", longint'(delayCount), MAXV);

    // Seeded random stream over a small tag range to mix hits and misses
    doReset();
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a = mk(int'($urandom % 6), int'($urandom % SETS), int'($urandom % 16));
      logic wr = (($urandom % 3) == 0);
      doAcc(a, wr, -1, wr ? "R5" : "R3");
    end
    checkCounters("R7");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule